// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block is the receive side of an asynchronous serial port. It synchronizes the incoming line and looks for a falling edge. It checks that the start bit is still low at mid-bit, then samples each later bit at its centre on a 16x oversampling tick. The sampled bits are assembled into an 8-bit word, least significant bit first. An optional parity bit follows, and then the stop bit. When a frame ends, the receiver decides three things: whether the word goes into the holding register, whether the data-full flag is raised, and which of the overrun, framing and parity flags latch.

Software-side behaviour is reduced to two strobes. A read strobe tells the block that the holding register has been consumed. A clear strobe carries a three-bit mask that selects which error flags to drop. One enable input gates both the data interrupt and the error interrupt. While any error flag is set, the receiver ignores the line completely until every error flag has been cleared.

Top module: `serial_rx`

## Requirements
- R1: Data bits are taken least significant bit first. There are DATA_W bits, each sampled at the centre of its bit period, and the start bit is recognised only on a high-to-low transition of the line.
- R2: With `par_en_i`=1, the bit after the data is parity. `par_odd_i`=0 means an even count of ones over data plus parity is correct, and `par_odd_i`=1 means an odd count is correct. A mismatch sets `par_err_o`.
- R3: A stop bit sampled as 0 sets `frm_err_o`. The word is still written to `rx_data_o`, but `rx_full_o` is not set.
- R4: If `rx_full_o` is 1 when a frame ends, `ovr_err_o` is set and `rx_data_o` keeps its old value.
- R5: `rx_full_o` is set only by a frame with no error. While any error flag is 1, frames on the line change neither `rx_data_o` nor any flag.
- R6: A pulse on `err_clr_i` clears each error flag whose bit in `err_clr_mask_i` is 1 (bit 0 overrun, bit 1 framing, bit 2 parity) and leaves the other flags alone. Without such a pulse, error flags hold their value. A flag being set in the same cycle as its clear ends up set.
- R7: With `two_stop_i`=1, only the first stop bit is checked. A low second stop bit raises no error and does not start a frame.
- R8: A low pulse on the line that is shorter than half a bit is rejected as noise, with no effect on data or flags.
- R9: `rx_irq_o` equals `rx_full_o` AND `irq_en_i`. `err_irq_o` equals (any error flag) AND `irq_en_i`.
- R10: A pulse on `rd_strobe_i` clears `rx_full_o` and leaves `rx_data_o` unchanged.
- R11: With `par_en_i`=0, the bit right after the data is taken as the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling tick, OVS per bit |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| two_stop_i | input | 1 | 1 = two stop bits in the frame |
| irq_en_i | input | 1 | Enable for both interrupts |
| rd_strobe_i | input | 1 | Holding register consumed |
| err_clr_i | input | 1 | Clear selected error flags |
| err_clr_mask_i | input | 3 | Flags to clear: [0] overrun, [1] framing, [2] parity |
| rx_data_o | output | DATA_W | Holding register |
| rx_full_o | output | 1 | Data-full flag |
| ovr_err_o | output | 1 | Overrun flag |
| frm_err_o | output | 1 | Framing flag |
| par_err_o | output | 1 | Parity flag |
| rx_irq_o | output | 1 | Data interrupt |
| err_irq_o | output | 1 | Error interrupt |

## Verification
The bench builds the receiver with DATA_W=8 and OVS=8 and issues a tick on every other clock. A bit therefore lasts 16 clocks, and one full frame fits in a few hundred cycles. This lets a single run cover both parity senses, both stop-bit settings, every error class, the lock-out while errors are pending, and a runt start pulse. The mid-bit threshold of four ticks is short enough that a four-clock low pulse falls clearly below it.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_STOP2
  } rx_state_e;

  localparam int ERR_OVR = 0;
  localparam int ERR_FRM = 1;
  localparam int ERR_PAR = 2;
  localparam int ERR_N   = 3;
endpackage

// File: rtl/rx_rst_sync.sv
module rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              hold_i,
  input  logic              par_en_i,
  input  logic              two_stop_i,
  output logic              done_o,
  output logic              stop_o,
  output logic              pbit_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int CW   = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int BW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HALF = OVS / 2;
  localparam logic [CW-1:0] CNT_HALF = CW'(HALF - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bits_q, bits_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic              pbit_q, pbit_d;
  logic              prev_q;
  logic              mid_bit;

  assign mid_bit = tick_i && (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bits_d  = bits_q;
    shf_d   = shf_q;
    pbit_d  = pbit_q;
    done_o  = 1'b0;
    if (tick_i && state_q != RX_IDLE) cnt_d = cnt_q + 1'b1;
    unique case (state_q)
      RX_IDLE: begin
        if (tick_i && prev_q && !line_i && !hold_i) begin
          state_d = RX_START;
          cnt_d   = '0;
        end
      end
      RX_START: begin
        if (tick_i && cnt_q == CNT_HALF) begin
          cnt_d   = '0;
          bits_d  = '0;
          state_d = line_i ? RX_IDLE : RX_DATA;
        end
      end
      RX_DATA: begin
        if (mid_bit) begin
          cnt_d = '0;
          shf_d = {line_i, shf_q[DATA_W-1:1]};
          if (bits_q == BIT_LAST) state_d = par_en_i ? RX_PAR : RX_STOP;
          else                    bits_d  = bits_q + 1'b1;
        end
      end
      RX_PAR: begin
        if (mid_bit) begin
          cnt_d   = '0;
          pbit_d  = line_i;
          state_d = RX_STOP;
        end
      end
      RX_STOP: begin
        if (mid_bit) begin
          cnt_d   = '0;
          done_o  = 1'b1;
          state_d = two_stop_i ? RX_STOP2 : RX_IDLE;
        end
      end
      RX_STOP2: begin
        if (mid_bit) state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bits_q  <= '0;
      shf_q   <= '0;
      pbit_q  <= 1'b0;
      prev_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bits_q  <= bits_d;
      shf_q   <= shf_d;
      pbit_q  <= pbit_d;
      if (tick_i) prev_q <= line_i;
    end
  end

  assign stop_o = line_i;
  assign pbit_o = pbit_q;
  assign word_o = shf_q;
endmodule

// File: rtl/rx_flags.sv
module rx_flags
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic              stop_i,
  input  logic              pbit_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rd_i,
  input  logic              clr_i,
  input  logic [ERR_N-1:0]  clr_mask_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic [ERR_N-1:0]  err_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q, full_d;
  logic [ERR_N-1:0]  err_q, err_d, hit, clr_v;
  logic              load;

  always_comb begin
    hit          = '0;
    hit[ERR_OVR] = done_i && full_q;
    hit[ERR_FRM] = done_i && !stop_i;
    hit[ERR_PAR] = done_i && par_en_i && (^word_i ^ pbit_i ^ par_odd_i);
    load         = done_i && !full_q;
    clr_v        = clr_i ? clr_mask_i : '0;
    err_d        = hit | (err_q & ~clr_v);
    full_d       = (load && !hit[ERR_FRM] && !hit[ERR_PAR]) || (full_q && !rd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      err_q  <= '0;
    end else begin
      if (load) data_q <= word_i;
      full_q <= full_d;
      err_q  <= err_d;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign err_o  = err_q;
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic              tick_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              irq_en_i,
  input  logic              rd_strobe_i,
  input  logic              err_clr_i,
  input  logic [2:0]        err_clr_mask_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              ovr_err_o,
  output logic              frm_err_o,
  output logic              par_err_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);
  logic              rst_n_s;
  logic              line;
  logic              done, stop_bit, pbit;
  logic [DATA_W-1:0] word;
  logic [ERR_N-1:0]  err;

  rx_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (rxd_i),
    .q_o   (line)
  );

  rx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .tick_i     (tick_i),
    .line_i     (line),
    .hold_i     (|err),
    .par_en_i   (par_en_i),
    .two_stop_i (two_stop_i),
    .done_o     (done),
    .stop_o     (stop_bit),
    .pbit_o     (pbit),
    .word_o     (word)
  );

  rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .done_i     (done),
    .stop_i     (stop_bit),
    .pbit_i     (pbit),
    .word_i     (word),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .rd_i       (rd_strobe_i),
    .clr_i      (err_clr_i),
    .clr_mask_i (err_clr_mask_i),
    .data_o     (rx_data_o),
    .full_o     (rx_full_o),
    .err_o      (err)
  );

  assign ovr_err_o = err[ERR_OVR];
  assign frm_err_o = err[ERR_FRM];
  assign par_err_o = err[ERR_PAR];
  assign rx_irq_o  = rx_full_o && irq_en_i;
  assign err_irq_o = (|err) && irq_en_i;
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_en_i,
  input logic              err_clr_i,
  input logic [2:0]        err_clr_mask_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_full_o,
  input logic              ovr_err_o,
  input logic              frm_err_o,
  input logic              par_err_o,
  input logic              rx_irq_o,
  input logic              err_irq_o
);
  AST_FULL_ONLY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full_o) |-> !(ovr_err_o || frm_err_o || par_err_o)); // R5

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err_o) |-> $stable(rx_data_o)); // R4

  AST_ERR_LOCKS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err_o || frm_err_o || par_err_o) |=> $stable(rx_data_o)); // R5

  AST_FRM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frm_err_o) |-> $past(err_clr_i && err_clr_mask_i[1])); // R6

  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(par_err_o) |-> $past(err_clr_i && err_clr_mask_i[2])); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> (!rx_irq_o && !err_irq_o)); // R9
endmodule

bind serial_rx serial_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .irq_en_i       (irq_en_i),
  .err_clr_i      (err_clr_i),
  .err_clr_mask_i (err_clr_mask_i),
  .rx_data_o      (rx_data_o),
  .rx_full_o      (rx_full_o),
  .ovr_err_o      (ovr_err_o),
  .frm_err_o      (frm_err_o),
  .par_err_o      (par_err_o),
  .rx_irq_o       (rx_irq_o),
  .err_irq_o      (err_irq_o)
);

// File: tb/serial_rx_tb.sv
`timescale 1ns/1ps
module serial_rx_tb;
  localparam int DW      = 8;
  localparam int OVS     = 8;
  localparam int BIT_CLK = OVS * 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1, tick = 1'b0;
  logic par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0, irq_en = 1'b0;
  logic rd = 1'b0, clr = 1'b0;
  logic [2:0] clr_mask = 3'b000;
  logic [DW-1:0] rx_data;
  logic full, ovr, frm, par, rx_irq, err_irq;

  int n_chk = 0, n_fail = 0;
  logic mdl_on = 1'b0;
  logic [DW-1:0] e_data = '0;
  logic e_full = 0, e_ovr = 0, e_frm = 0, e_par = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) tick <= rst_n ? ~tick : 1'b0;

  serial_rx #(.DATA_W(DW), .OVS(OVS)) u_dut (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick_i(tick),
    .par_en_i(par_en), .par_odd_i(par_odd), .two_stop_i(two_stop),
    .irq_en_i(irq_en), .rd_strobe_i(rd), .err_clr_i(clr),
    .err_clr_mask_i(clr_mask), .rx_data_o(rx_data), .rx_full_o(full),
    .ovr_err_o(ovr), .frm_err_o(frm), .par_err_o(par),
    .rx_irq_o(rx_irq), .err_irq_o(err_irq));

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // every-clock comparison against the behavioural model
  always @(negedge clk) if (mdl_on) begin
    chk("model data", rx_data, e_data);
    chk("model full", full, e_full);
    chk("model ovr", ovr, e_ovr);
    chk("model frm", frm, e_frm);
    chk("model par", par, e_par);
    chk("model R9 rx_irq", rx_irq, e_full & irq_en);
    chk("model R9 err_irq", err_irq, (e_ovr | e_frm | e_par) & irq_en);
  end

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (BIT_CLK) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [DW-1:0] d, input logic pb, input logic s1, input logic s2);
    int ones;
    logic perr;
    mdl_on = 1'b0;
    @(posedge clk); #1;
    hold_bit(1'b0);
    for (int i = 0; i < DW; i++) hold_bit(d[i]);
    if (par_en) hold_bit(pb);
    hold_bit(s1);
    if (two_stop) hold_bit(s2);
    rxd = 1'b1;
    repeat (3 * BIT_CLK) @(posedge clk);
    #1;
    if (!(e_ovr || e_frm || e_par)) begin
      ones = $countones(d) + int'(pb);
      perr = par_en && ((ones % 2) != (par_odd ? 1 : 0));
      if (!e_full) e_data = d;
      if (e_full) e_ovr = 1'b1;
      if (!s1) e_frm = 1'b1;
      if (perr) e_par = 1'b1;
      if (!e_full && s1 && !perr) e_full = 1'b1;
    end
    mdl_on = 1'b1;
  endtask

  task automatic do_read();
    mdl_on = 1'b0;
    @(posedge clk); #1; rd = 1'b1;
    @(posedge clk); #1; rd = 1'b0;
    e_full = 1'b0;
    mdl_on = 1'b1;
  endtask

  task automatic do_clear(input logic [2:0] m);
    mdl_on = 1'b0;
    @(posedge clk); #1; clr = 1'b1; clr_mask = m;
    @(posedge clk); #1; clr = 1'b0; clr_mask = 3'b000;
    if (m[0]) e_ovr = 1'b0;
    if (m[1]) e_frm = 1'b0;
    if (m[2]) e_par = 1'b0;
    mdl_on = 1'b1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("reset full", full, 0);
    chk("reset errors", {ovr, frm, par}, 0);
    chk("reset data", rx_data, 0);
    mdl_on = 1'b1;

    // R1 R11: no parity, one stop bit, LSB first
    send(8'hA5, 1'b0, 1'b1, 1'b1);
    @(negedge clk); chk("R1 data A5", rx_data, 8'hA5);
    chk("R11 stop after data", frm, 0);
    chk("R9 irq gated off", rx_irq, 0);
    // R10
    do_read(); @(negedge clk);
    chk("R10 full cleared", full, 0);
    chk("R10 data kept", rx_data, 8'hA5);
    // R9
    irq_en = 1'b1;
    send(8'h3C, 1'b0, 1'b1, 1'b1);
    @(negedge clk); chk("R1 data 3C", rx_data, 8'h3C);
    chk("R9 rx_irq", rx_irq, 1);
    do_read();
    // R2 even parity
    par_en = 1'b1;
    send(8'h0F, 1'b0, 1'b1, 1'b1);
    @(negedge clk); chk("R2 even ok", {full, par}, 2'b10);
    do_read();
    send(8'h07, 1'b0, 1'b1, 1'b1);
    @(negedge clk); chk("R2 even bad", par, 1);
    chk("R2 data loaded", rx_data, 8'h07);
    chk("R5 full blocked", full, 0);
    chk("R9 err_irq", err_irq, 1);
    // R5 lock-out
    send(8'hEE, 1'b0, 1'b1, 1'b1);
    @(negedge clk); chk("R5 data locked", rx_data, 8'h07);
    // R6 mask selects
    do_clear(3'b011); @(negedge clk);
    chk("R6 parity kept", par, 1);
    do_clear(3'b100); @(negedge clk);
    chk("R6 parity cleared", par, 0);
    // R2 odd parity
    par_odd = 1'b1;
    send(8'h07, 1'b0, 1'b1, 1'b1);
    @(negedge clk); chk("R2 odd ok", {full, par}, 2'b10);
    do_read();
    // R3 framing
    par_en = 1'b0;
    send(8'h96, 1'b0, 1'b0, 1'b1);
    @(negedge clk); chk("R3 frm set", frm, 1);
    chk("R3 data loaded", rx_data, 8'h96);
    chk("R3 full clear", full, 0);
    do_clear(3'b010);
    // R4 overrun
    send(8'h11, 1'b0, 1'b1, 1'b1);
    send(8'h22, 1'b0, 1'b1, 1'b1);
    @(negedge clk); chk("R4 ovr set", ovr, 1);
    chk("R4 data kept", rx_data, 8'h11);
    chk("R4 full kept", full, 1);
    do_clear(3'b001); do_read();
    // R7 two stop bits, second low ignored
    two_stop = 1'b1;
    send(8'hC3, 1'b0, 1'b1, 1'b0);
    @(negedge clk); chk("R7 no frm", frm, 0);
    chk("R7 data", rx_data, 8'hC3);
    repeat (4 * BIT_CLK) @(negedge clk);
    chk("R7 no spurious frame", {ovr, full}, 2'b01);
    do_read();
    two_stop = 1'b0;
    // R8 runt start pulse
    mdl_on = 1'b0;
    @(posedge clk); #1 rxd = 1'b0;
    repeat (4) @(posedge clk);
    #1 rxd = 1'b1;
    repeat (4 * BIT_CLK) @(posedge clk);
    @(negedge clk);
    chk("R8 noise ignored", {full, ovr, frm, par}, 0);
    chk("R8 data unchanged", rx_data, 8'hC3);
    mdl_on = 1'b1;
    send(8'h5A, 1'b0, 1'b1, 1'b1);
    @(negedge clk); chk("R8 next frame", rx_data, 8'h5A);
    finish_run();
  end
endmodule